// File: doc/BRIEF.md
# Segmented Binary-to-Residue Converter

This block reduces an unsigned binary word modulo a fixed modulus `MOD` of at most five bits. It uses no lookup memory at any point. The word is cut into 2-bit slices. Each slice, taken at its positional weight 4^k, is mapped to a partial residue by a small constant-driven multiplexer.

The partial residues are merged into a sum vector and a carry vector by a carry-save array. Their total is then folded into two operands, each below `MOD`, so that the pair sums to less than 2·MOD. A two-operand modular adder forms both `s` and `s − MOD` and keeps whichever is non-negative.

The datapath is fully pipelined. It accepts one word per clock and returns its residue after a fixed four-cycle latency, and a valid flag travels with each word.

Top module: `seg_b2r_converter`

## Requirements
- R1: For every accepted word `x`, the output residue equals `x mod MOD`.
- R2: Every residue presented with `out_valid` high lies in the range 0 to MOD−1.
- R3: A word sampled with `in_valid` high at clock edge n appears with `out_valid` high immediately after edge n+3, which is a latency of four registers.
- R4: A new word can be accepted on every clock edge. N consecutive valid inputs yield N consecutive valid outputs.
- R5: Reset is synchronous and active high. It clears every stage's valid flag, so `out_valid` is low after any edge that sees reset, and words in flight at reset are never presented.
- R6: A cycle with `in_valid` low produces a cycle with `out_valid` low four edges later.
- R7: The generator for slice k (bits 2k+1:2k) outputs `(d · 4^k) mod MOD` for slice value d in 0..3, which is always below MOD.
- R8: The sum and carry vectors leaving the carry-save array add, modulo 2^SW, to the exact total of all partial residues.
- R9: The folding stage produces two operands, each below MOD, whose sum is below 2·MOD and congruent to the array total.
- R10: The final adder outputs `s − MOD` when `s ≥ MOD`, and `s` otherwise. A sum of exactly MOD gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset for the valid pipeline |
| in_valid | input | 1 | Qualifies `in_word` on this edge |
| in_word | input | W_IN | Unsigned binary operand |
| out_valid | output | 1 | Qualifies `out_residue` |
| out_residue | output | RW = clog2(MOD) | `in_word mod MOD` |

## Verification
The hardest internal situation to reach from the ports is the low fold branch firing while the final adder sum lands exactly on MOD. These only occur for particular mixes of slice residues. The stimulus therefore sweeps every word from 0 to 1023 back-to-back, which walks the low slices through all combinations. It also drives multiples of MOD, one-hot slice patterns and a long seeded random run that covers the high slices. A reset placed in the middle of a burst confirms that in-flight words vanish.

// File: rtl/b2r_pkg.sv
package b2r_pkg;

   // Number of 2-bit slices needed to cover a word of width w.
   function automatic int slice_count(input int w);
      return (w + 1) / 2;
   endfunction

   // 2^e mod m, computed by repeated doubling.
   function automatic int pow2_mod(input int e, input int m);
      int r;
      r = 1 % m;
      for (int i = 0; i < e; i++) r = (r * 2) % m;
      return r;
   endfunction

   // Width that holds the value v.
   function automatic int bits_for(input int v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/b2r_seg_modgen.sv
module b2r_seg_modgen #(
   parameter int MOD = 29,
   parameter int RW  = 5,
   parameter int IDX = 0
) (
   input  logic [1:0]    slice,
   output logic [RW-1:0] part
);
   import b2r_pkg::*;

   // Residue of the slice weight 4^IDX and its small multiples.
   localparam int WT1 = pow2_mod(2 * IDX, MOD);
   localparam int WT2 = (2 * WT1) % MOD;
   localparam int WT3 = (3 * WT1) % MOD;

   always_comb begin
      unique case (slice)
         2'd0:    part = '0;
         2'd1:    part = RW'(WT1);
         2'd2:    part = RW'(WT2);
         default: part = RW'(WT3);
      endcase
   end
endmodule

// File: rtl/b2r_csa_array.sv
module b2r_csa_array #(
   parameter int NOPS = 8,
   parameter int RW   = 5,
   parameter int SW   = 8
) (
   input  logic [NOPS-1:0][RW-1:0] ops,
   output logic [SW-1:0]           sum_vec,
   output logic [SW-1:0]           car_vec
);
   logic [SW-1:0] s_ch [NOPS];
   logic [SW-1:0] c_ch [NOPS];

   assign s_ch[0] = SW'(ops[0]);
   assign c_ch[0] = '0;

   generate
      for (genvar i = 1; i < NOPS; i++) begin : g_level
         logic [SW-1:0] x;
         assign x       = SW'(ops[i]);
         assign s_ch[i] = s_ch[i-1] ^ c_ch[i-1] ^ x;
         assign c_ch[i] = ((s_ch[i-1] & c_ch[i-1]) |
                           (s_ch[i-1] & x) |
                           (c_ch[i-1] & x)) << 1;
      end
   endgenerate

   assign sum_vec = s_ch[NOPS-1];
   assign car_vec = c_ch[NOPS-1];
endmodule

// File: rtl/b2r_range_fold.sv
module b2r_range_fold #(
   parameter int MOD = 29,
   parameter int RW  = 5,
   parameter int SW  = 8
) (
   input  logic [SW-1:0] sum_vec,
   input  logic [SW-1:0] car_vec,
   output logic [RW-1:0] op_lo,
   output logic [RW-1:0] op_hi
);
   import b2r_pkg::*;

   localparam int HW   = SW - RW;
   localparam int NH   = 1 << HW;
   localparam int HWGT = pow2_mod(RW, MOD);

   logic [SW-1:0] total;
   logic [RW-1:0] lo_bits;
   logic [HW-1:0] hi_bits;
   logic [RW-1:0] hi_tab [NH];

   assign total   = sum_vec + car_vec;
   assign lo_bits = total[RW-1:0];
   assign hi_bits = total[SW-1:RW];

   // The low field is below 2^RW <= 2*MOD, so one conditional subtract suffices.
   always_comb begin
      if (int'(lo_bits) >= MOD) op_lo = RW'(int'(lo_bits) - MOD);
      else                      op_lo = lo_bits;
   end

   // Residue of the high field at weight 2^RW, one constant per value.
   generate
      for (genvar h = 0; h < NH; h++) begin : g_hi
         assign hi_tab[h] = RW'((h * HWGT) % MOD);
      end
   endgenerate

   assign op_hi = hi_tab[hi_bits];
endmodule

// File: rtl/b2r_mod_add.sv
module b2r_mod_add #(
   parameter int MOD = 29,
   parameter int RW  = 5
) (
   input  logic [RW-1:0] a,
   input  logic [RW-1:0] b,
   output logic [RW-1:0] res
);
   logic [RW:0]   s_raw;
   logic [RW+1:0] s_sub;

   assign s_raw = {1'b0, a} + {1'b0, b};
   assign s_sub = {1'b0, s_raw} - (RW+2)'(MOD);
   assign res   = s_sub[RW+1] ? s_raw[RW-1:0] : s_sub[RW-1:0];
endmodule

// File: rtl/seg_b2r_converter.sv
module seg_b2r_converter #(
   parameter  int W_IN = 16,
   parameter  int MOD  = 29,
   localparam int RW   = $clog2(MOD)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [W_IN-1:0] in_word,
   output logic            out_valid,
   output logic [RW-1:0]   out_residue
);
   import b2r_pkg::*;

   localparam int NSEG = slice_count(W_IN);
   localparam int PW   = 2 * NSEG;
   localparam int SW   = bits_for(NSEG * (MOD - 1));

   generate
      if (MOD < 3 || MOD > 31) begin : g_bad_mod
         $error("MOD must lie in 3..31");
      end
      if (W_IN < 4) begin : g_bad_width
         $error("W_IN must be at least 4");
      end
   endgenerate

   // Stage 1: slice generators
   logic [PW-1:0]             word_pad;
   logic [NSEG-1:0][RW-1:0]   part_c;
   logic [NSEG-1:0][RW-1:0]   s1_part;
   logic                      s1_valid;

   assign word_pad = PW'(in_word);

   generate
      for (genvar k = 0; k < NSEG; k++) begin : g_seg
         b2r_seg_modgen #(.MOD(MOD), .RW(RW), .IDX(k)) u_gen (
            .slice (word_pad[2*k+1:2*k]),
            .part  (part_c[k])
         );
      end
   endgenerate

   // Stage 2: carry-save merge
   logic [SW-1:0] sum_c, car_c;
   logic [SW-1:0] s2_sum, s2_car;
   logic          s2_valid;

   b2r_csa_array #(.NOPS(NSEG), .RW(RW), .SW(SW)) u_csa (
      .ops     (s1_part),
      .sum_vec (sum_c),
      .car_vec (car_c)
   );

   // Stage 3: fold below 2*MOD
   logic [RW-1:0] lo_c, hi_c;
   logic [RW-1:0] s3_lo, s3_hi;
   logic          s3_valid;

   b2r_range_fold #(.MOD(MOD), .RW(RW), .SW(SW)) u_fold (
      .sum_vec (s2_sum),
      .car_vec (s2_car),
      .op_lo   (lo_c),
      .op_hi   (hi_c)
   );

   // Stage 4: final modular addition
   logic [RW-1:0] res_c;

   b2r_mod_add #(.MOD(MOD), .RW(RW)) u_add (
      .a   (s3_lo),
      .b   (s3_hi),
      .res (res_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid  <= 1'b0;
         s2_valid  <= 1'b0;
         s3_valid  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_valid  <= in_valid;
         s2_valid  <= s1_valid;
         s3_valid  <= s2_valid;
         out_valid <= s3_valid;
      end
   end

   always_ff @(posedge clk) begin
      s1_part     <= part_c;
      s2_sum      <= sum_c;
      s2_car      <= car_c;
      s3_lo       <= lo_c;
      s3_hi       <= hi_c;
      out_residue <= res_c;
   end

   // ---------------- assertions ----------------
   logic [SW-1:0] s1_total;
   logic [2:0]    since_rst;

   always_comb begin
      s1_total = '0;
      for (int k = 0; k < NSEG; k++) s1_total = s1_total + SW'(s1_part[k]);
   end

   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= '0;
      else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
   end

   generate
      for (genvar k = 0; k < NSEG; k++) begin : g_chk
         a_r7_slice_below_mod: assert property (@(posedge clk) disable iff (rst)
            s1_valid |-> (int'(s1_part[k]) < MOD));
      end
   endgenerate

   a_r8_csa_total: assert property (@(posedge clk) disable iff (rst)
      s2_valid |-> (SW'(s2_sum + s2_car) == $past(s1_total)));

   a_r9_fold_range: assert property (@(posedge clk) disable iff (rst)
      s3_valid |-> ((int'(s3_lo) < MOD) && (int'(s3_hi) < MOD)));

   a_r2_out_range: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_residue) < MOD));

   a_r5_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);

   a_r3_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

   a_r1_residue: assert property (@(posedge clk) disable iff (rst)
      ((since_rst == 3'd4) && out_valid) |->
         (int'(out_residue) == int'($past(in_word, 4)) % MOD));

endmodule

// File: tb/tb_seg_b2r_converter.sv
module tb_seg_b2r_converter;
   localparam int TW = 16;
   localparam int TM = 29;
   localparam int TR = $clog2(TM);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [TW-1:0] in_word = '0;
   logic          out_valid;
   logic [TR-1:0] out_residue;

   int checks = 0;
   int fails  = 0;
   int outs_seen = 0;

   bit    pv [4];
   int    pd [4];
   string pt [4];

   always #4 clk = ~clk;

   seg_b2r_converter #(.W_IN(TW), .MOD(TM)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_residue(out_residue)
   );

   function automatic int ref_mod(input logic [TW-1:0] w);
      return int'(w) % TM;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit r, input bit v, input logic [TW-1:0] w, input string tag);
      @(negedge clk);
      rst = r; in_valid = v; in_word = w;
      @(posedge clk);
      #2;
      if (r) begin
         for (int i = 0; i < 4; i++) pv[i] = 1'b0;
      end else begin
         for (int i = 3; i > 0; i--) begin
            pv[i] = pv[i-1]; pd[i] = pd[i-1]; pt[i] = pt[i-1];
         end
         pv[0] = v; pd[0] = ref_mod(w); pt[0] = tag;
      end
      if (out_valid === 1'b1) outs_seen++;
      chk(out_valid === pv[3], r ? "R5" : (pv[3] ? "R3" : "R6"), int'(out_valid), int'(pv[3]));
      if (pv[3] && out_valid === 1'b1) begin
         chk(int'(out_residue) == pd[3], pt[3], int'(out_residue), pd[3]);
         chk(int'(out_residue) < TM, "R2", int'(out_residue), TM - 1);
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int base;
      void'($urandom(32'd2024));

      // reset state (R5)
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 16'hFFFF, "R5");

      // directed corners
      step(1'b0, 1'b1, 16'h0000, "R1");
      step(1'b0, 1'b1, 16'hFFFF, "R8");
      step(1'b0, 1'b1, 16'(TM), "R10");
      step(1'b0, 1'b1, 16'(2 * TM), "R10");
      step(1'b0, 1'b1, 16'(TM * 2259), "R10");
      step(1'b0, 1'b1, 16'(TM - 1), "R2");
      for (int k = 0; k < TW / 2; k++) step(1'b0, 1'b1, 16'(3 << (2 * k)), "R7");
      for (int k = 0; k < TW; k++)     step(1'b0, 1'b1, 16'(1 << k), "R7");
      for (int i = 0; i < 6; i++)      step(1'b0, 1'b0, 16'hAAAA, "R6");

      // exhaustive low sweep, back-to-back (R9, R4)
      base = outs_seen;
      for (int w = 0; w < 1024; w++) step(1'b0, 1'b1, 16'(w), "R9");
      for (int i = 0; i < 4; i++)    step(1'b0, 1'b0, 16'h0, "R6");
      chk(outs_seen - base == 1024, "R4", outs_seen - base, 1024);

      // seeded random mix of valid and idle
      for (int i = 0; i < 3000; i++) begin
         logic [TW-1:0] w;
         w = 16'($urandom);
         step(1'b0, ($urandom % 4) != 0, w, "R1");
      end

      // reset with words in flight (R5)
      step(1'b0, 1'b1, 16'h1234, "R1");
      step(1'b0, 1'b1, 16'h4321, "R1");
      step(1'b0, 1'b1, 16'hBEEF, "R1");
      base = outs_seen;
      step(1'b1, 1'b0, 16'h0, "R5");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 16'h0, "R5");
      chk(outs_seen == base, "R5", outs_seen - base, 0);

      // restart after reset and drain
      step(1'b0, 1'b1, 16'hFFFE, "R1");
      step(1'b0, 1'b1, 16'h8000, "R1");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 16'h0, "R6");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule